// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block holds the status byte of a serial flash slave and decides which write-type operations may go ahead. It watches a mode-0 SPI stream (clock, active-low select, data in) that has already been brought into the system clock domain. It decodes three single-byte instructions: set the write latch, read the status byte, and write the protection fields. It drives the status byte back on the serial data output for as long as the host keeps clocking.

The memory array controller sends program and erase requests through a one-cycle request port. The block answers each one with a single-cycle permit or refuse pulse. It refuses when the write latch is clear, when the unit is busy, when the target lies in the protected region, or when a whole-chip erase is attempted while any protection level is set. A permitted request, or an accepted status write, starts a busy timer whose length is a parameter. The protection fields are kept in plain registers, and reset clears them.

Top module: `sflash_status_unit`

## Requirements
- R1: After reset the status byte reads 0x00, and so_en, miso, req_grant and req_deny are all low.
- R2: The status byte is {lock, 0, 0, 0, level[1], level[0], latch, busy}, from bit 7 down to bit 0. After the 8-bit opcode 0x05 is sampled on rising sclk edges (MSB first), the status goes out MSB first. Its first bit is driven on the falling edge that ends the opcode, and so_en is high while it is being driven.
- R3: While cs_n stays low after opcode 0x05, the status byte is sent again and again. A fresh copy is taken at the start of each byte, so the busy bit reads 1 during a running operation.
- R4: Opcode 0x06 sets the latch only when cs_n rises after exactly 8 bits and the unit is not busy. A frame of any other length has no effect.
- R5: Opcode 0x01 followed by one data byte, closed after exactly 16 bits, is accepted when the latch is set, the unit is idle and hardware lock is off. On acceptance, level takes data bits 3:2 and lock takes data bit 7. Data bits 6:4 and 1:0 are discarded, and the busy timer starts.
- R6: When the latch is clear or the unit is busy, a status write changes nothing. An array request in that state gets req_deny and starts nothing.
- R7: When lock is 1 and wp_n is low, a status write is refused. Lock and level keep their values, and the latch is cleared.
- R8: req_op encodes 0 as page program, 1 as sector erase, 2 as block erase and 3 as chip erase. Level 0 protects nothing. With the default parameters, level 1 protects addresses at 0xC000 and above, level 2 protects 0x8000 and above, and level 3 protects everything. A decision appears as a one-cycle pulse in the cycle after req_valid. A refusal caused by protection clears the latch.
- R9: Chip erase is permitted only when both level bits are 0.
- R10: Busy stays high for exactly BUSY_CYCLES cycles, beginning with the cycle after acceptance. The latch clears at the moment busy ends.
- R11: req_grant and req_deny are never high together. A request made while busy is refused and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, already synchronised to clk |
| cs_n | input | 1 | Active-low chip select, already synchronised |
| mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| miso | output | 1 | Serial data to host |
| so_en | output | 1 | High while miso carries status data |
| req_valid | input | 1 | One-cycle array operation request |
| req_op | input | 2 | Operation kind: 0 page, 1 sector, 2 block, 3 chip |
| req_addr | input | ADDR_W | Target address of the request |
| req_grant | output | 1 | Request permitted, busy started |
| req_deny | output | 1 | Request refused |

## Verification
The checker assumes that sclk and cs_n are synchronous to clk and that each sclk level lasts at least two clock cycles. It also assumes that cs_n never changes in the same cycle as an sclk edge, and that req_valid never coincides with a command that closes a frame. The bench drives every input on the falling edge of clk. It holds each sclk phase for two cycles and leaves cs_n settled for two cycles before and after a frame. It issues requests only between frames. Reads that must fall inside a busy window are timed so that every byte snapshot lands well before the timer expires.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;

    typedef enum logic [1:0] {
        REQ_PAGE   = 2'd0,
        REQ_SECTOR = 2'd1,
        REQ_BLOCK  = 2'd2,
        REQ_CHIP   = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] level;
        logic       latch;
    } sreg_t;

    function automatic logic [7:0] pack_status(sreg_t s, logic busy);
        return {s.lock, 3'b000, s.level, s.latch, busy};
    endfunction

endpackage

// File: rtl/sfs_spi_rx.sv
module sfs_spi_rx
    import sfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic [7:0] opcode,
    output logic       opcode_valid,
    output logic       cmd_wren,
    output logic       cmd_wrsr,
    output logic       wr_lock,
    output logic [1:0] wr_level,
    output logic       sclk_fall
);

    localparam int CNT_W = 5;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             sclk;
        logic             cs_n;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [7:0]       opc;
        logic             dlock;
        logic [1:0]       dlevel;
        logic             wren;
        logic             wrsr;
    } rx_t;

    rx_t rx_d, rx_q;
    logic rise;

    always_comb begin
        rx_d      = rx_q;
        rx_d.sclk = sclk;
        rx_d.cs_n = cs_n;
        rx_d.wren = 1'b0;
        rx_d.wrsr = 1'b0;
        rise      = sclk & ~rx_q.sclk;
        if (cs_n) begin
            rx_d.cnt = '0;
            if (!rx_q.cs_n) begin
                if (rx_q.cnt == CNT_W'(8)  && rx_q.opc == OPC_WREN) rx_d.wren = 1'b1;
                if (rx_q.cnt == CNT_W'(16) && rx_q.opc == OPC_WRSR) rx_d.wrsr = 1'b1;
            end
        end else if (rise) begin
            rx_d.sh = {rx_q.sh[6:0], mosi};
            if (rx_q.cnt != CNT_MAX) rx_d.cnt = rx_q.cnt + 1'b1;
            if (rx_q.cnt == CNT_W'(7)) rx_d.opc = {rx_q.sh[6:0], mosi};
            if (rx_q.cnt == CNT_W'(15)) begin
                rx_d.dlock  = rx_q.sh[6];
                rx_d.dlevel = rx_q.sh[2:1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.sclk <= 1'b0;
            rx_q.cs_n <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign opcode       = rx_q.opc;
    assign opcode_valid = !rx_q.cs_n && (rx_q.cnt >= CNT_W'(8));
    assign cmd_wren     = rx_q.wren;
    assign cmd_wrsr     = rx_q.wrsr;
    assign wr_lock      = rx_q.dlock;
    assign wr_level     = rx_q.dlevel;
    assign sclk_fall    = ~sclk & rx_q.sclk & ~cs_n;

endmodule

// File: rtl/sfs_status_tx.sv
module sfs_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk_fall,
    input  logic       rd_active,
    input  logic [7:0] status_byte,
    output logic       miso,
    output logic       so_en
);

    typedef struct packed {
        logic [2:0] idx;
        logic [7:0] sh;
        logic       drive;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (cs_n || !rd_active) begin
            tx_d = '0;
        end else if (sclk_fall) begin
            if (tx_q.idx == 3'd0) tx_d.sh = status_byte;
            else                  tx_d.sh = {tx_q.sh[6:0], 1'b0};
            tx_d.idx   = tx_q.idx + 3'd1;
            tx_d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign miso  = tx_q.sh[7];
    assign so_en = tx_q.drive;

endmodule

// File: rtl/sfs_busy_timer.sv
module sfs_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else if (start)   cnt_d = W'(CYCLES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == W'(1));

endmodule

// File: rtl/sfs_protect_map.sv
module sfs_protect_map #(
    parameter int ADDR_W    = 16,
    parameter int FRAC_LOG2 = 2
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [3:0] lvl_hit;

    assign lvl_hit[0] = 1'b0;

    for (genvar L = 1; L < 4; L++) begin : g_lvl
        localparam int K = FRAC_LOG2 - L + 1;
        if (K <= 0) begin : g_all
            assign lvl_hit[L] = 1'b1;
        end else begin : g_top
            localparam logic [ADDR_W:0] LIMIT =
                {1'b1, {ADDR_W{1'b0}}} - ({{ADDR_W{1'b0}}, 1'b1} << (ADDR_W - K));
            assign lvl_hit[L] = ({1'b0, addr} >= LIMIT);
        end
    end

    assign hit = lvl_hit[level];

endmodule

// File: rtl/sflash_status_unit.sv
module sflash_status_unit
    import sfs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int FRAC_LOG2   = 2,
    parameter int BUSY_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              wp_n,
    output logic              miso,
    output logic              so_en,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_grant,
    output logic              req_deny
);

    typedef struct packed {
        sreg_t sr;
        logic  grant;
        logic  deny;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [7:0] opcode;
    logic       opcode_valid, cmd_wren, cmd_wrsr, wr_lock, sclk_fall;
    logic [1:0] wr_level;
    logic       busy, busy_done, start, prot_hit, blocked, hw_lock, rd_active;
    logic [7:0] status_byte;

    sfs_spi_rx u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk         (sclk),
        .cs_n         (cs_n),
        .mosi         (mosi),
        .opcode       (opcode),
        .opcode_valid (opcode_valid),
        .cmd_wren     (cmd_wren),
        .cmd_wrsr     (cmd_wrsr),
        .wr_lock      (wr_lock),
        .wr_level     (wr_level),
        .sclk_fall    (sclk_fall)
    );

    assign rd_active   = opcode_valid && (opcode == OPC_RDSR);
    assign status_byte = pack_status(ctl_q.sr, busy);

    sfs_status_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk_fall   (sclk_fall),
        .rd_active   (rd_active),
        .status_byte (status_byte),
        .miso        (miso),
        .so_en       (so_en)
    );

    sfs_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (busy_done)
    );

    sfs_protect_map #(.ADDR_W(ADDR_W), .FRAC_LOG2(FRAC_LOG2)) u_map (
        .level (ctl_q.sr.level),
        .addr  (req_addr),
        .hit   (prot_hit)
    );

    assign hw_lock = ctl_q.sr.lock & ~wp_n;
    assign blocked = (req_op == REQ_CHIP) ? (ctl_q.sr.level != 2'b00) : prot_hit;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.grant = 1'b0;
        ctl_d.deny  = 1'b0;
        start       = 1'b0;
        if (busy_done) ctl_d.sr.latch = 1'b0;
        if (cmd_wrsr) begin
            if (ctl_q.sr.latch && !busy) begin
                if (hw_lock) begin
                    ctl_d.sr.latch = 1'b0;
                end else begin
                    ctl_d.sr.level = wr_level;
                    ctl_d.sr.lock  = wr_lock;
                    start          = 1'b1;
                end
            end
        end else if (cmd_wren) begin
            if (!busy) ctl_d.sr.latch = 1'b1;
        end
        if (req_valid) begin
            if (cmd_wrsr || cmd_wren || !ctl_q.sr.latch || busy) begin
                ctl_d.deny = 1'b1;
            end else if (blocked) begin
                ctl_d.deny     = 1'b1;
                ctl_d.sr.latch = 1'b0;
            end else begin
                ctl_d.grant = 1'b1;
                start       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_grant = ctl_q.grant;
    assign req_deny  = ctl_q.deny;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int BUSY_CYCLES = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       so_en,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       grant,
    input logic       deny,
    input logic       wip,
    input logic       wel,
    input logic       lock,
    input logic [1:0] level,
    input logic       wrsr_cmd
);

    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   busy_len <= 0;
        else if (wip) busy_len <= busy_len + 1;
        else          busy_len <= 0;
    end

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !so_en);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));

    p_busy_deny_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wip) |=> !grant);

    p_no_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wel) |=> !grant);

    p_chip_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && level != 2'b00) |=> !grant);

    p_hw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && lock) |=> ($stable(level) && $stable(lock)));

    p_hw_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_cmd && wel && !wip && lock && !wp_n) |=> !wel);

    p_grant_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> wip);

    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (busy_len == BUSY_CYCLES));

    p_done_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

endmodule

bind sflash_status_unit sfs_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wp_n      (wp_n),
    .so_en     (so_en),
    .req_valid (req_valid),
    .req_op    (req_op),
    .grant     (req_grant),
    .deny      (req_deny),
    .wip       (busy),
    .wel       (ctl_q.sr.latch),
    .lock      (ctl_q.sr.lock),
    .level     (ctl_q.sr.level),
    .wrsr_cmd  (cmd_wrsr)
);

// File: tb/tb_sflash_status_unit.sv
`timescale 1ns/1ps
module tb_sflash_status_unit;

    localparam int ADDR_W = 16;
    localparam int WAIT_DONE = 260;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso, so_en;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_grant, req_deny;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    always #2 clk = ~clk;

    sflash_status_unit dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .so_en(so_en), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .req_grant(req_grant),
        .req_deny(req_deny)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected status bytes as received bytes arrive
    always @(negedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(g == e, t, g, e);
        end
    end

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk) mosi = b;
        repeat (2) @(negedge clk);
        r = miso;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            spi_bit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cs_down();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_up();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [7:0] r;
        cs_down();
        spi_byte(op, r);
        cs_up();
    endtask

    task automatic send_wrsr(input logic [7:0] data);
        logic [7:0] r;
        cs_down();
        spi_byte(8'h01, r);
        spi_byte(data, r);
        cs_up();
    endtask

    // driver: pushes expectations, then collects the bytes
    task automatic read_status(input int n, input logic [7:0] exp, input string tag);
        logic [7:0] r;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        cs_down();
        spi_byte(8'h05, r);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, r);
            got_q.push_back(r);
        end
        cs_up();
    endtask

    task automatic request(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                           input bit exp_grant, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_grant == exp_grant && req_deny == !exp_grant, tag,
              {req_grant, req_deny}, {exp_grant, !exp_grant});
        @(negedge clk);
        check(!req_grant && !req_deny, {tag, " pulse"}, {req_grant, req_deny}, 0);
    endtask

    task automatic wait_done();
        repeat (WAIT_DONE) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic r;
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(!so_en && !miso && !req_grant && !req_deny, "R1 idle outputs",
              {so_en, miso, req_grant, req_deny}, 0);
        read_status(1, 8'h00, "R1 status after reset");

        // R4: 9-bit frame with the latch-set opcode does nothing
        cs_down();
        spi_byte(8'h06, rb);
        spi_bit(1'b0, r);
        cs_up();
        read_status(1, 8'h00, "R4 odd length frame ignored");

        // R4, R2, R3: latch set, continuous read
        send_cmd(8'h06);
        read_status(3, 8'h02, "R3 R2 repeated status latch set");

        // R5 accepted write, R3 readable while busy
        send_wrsr(8'h8C);
        read_status(2, 8'h8F, "R3 R5 status during write busy");
        wait_done();
        read_status(1, 8'h8C, "R10 latch cleared after write");

        // R8: level 3 protects everything, refusal clears latch
        send_cmd(8'h06);
        request(2'd0, 16'h0000, 1'b0, "R8 page into level 3");
        read_status(1, 8'h8C, "R8 refusal cleared latch");

        // R9: chip erase with level set
        send_cmd(8'h06);
        request(2'd3, 16'h0000, 1'b0, "R9 chip erase blocked");

        // R7: hardware lock
        wp_n = 1'b0;
        send_cmd(8'h06);
        send_wrsr(8'h00);
        read_status(1, 8'h8C, "R7 locked write refused");
        wp_n = 1'b1;

        // R5: unused data bits dropped, level 1, lock off
        send_cmd(8'h06);
        send_wrsr(8'h74);
        wait_done();
        read_status(1, 8'h04, "R5 fields loaded, bits 6:4 dropped");

        // R8: level 1 boundary
        send_cmd(8'h06);
        request(2'd0, 16'hBFFF, 1'b1, "R8 page below level 1 region");
        read_status(1, 8'h07, "R3 busy after grant");
        wait_done();
        read_status(1, 8'h04, "R10 latch cleared after program");
        send_cmd(8'h06);
        request(2'd1, 16'hC000, 1'b0, "R8 sector in level 1 region");

        // R6: no latch
        request(2'd2, 16'h0000, 1'b0, "R6 request without latch");
        send_wrsr(8'h00);
        read_status(1, 8'h04, "R6 write without latch ignored");

        // R8: level 2 boundary
        send_cmd(8'h06);
        send_wrsr(8'h08);
        wait_done();
        send_cmd(8'h06);
        request(2'd2, 16'h7FFF, 1'b1, "R8 block below level 2 region");
        wait_done();
        send_cmd(8'h06);
        request(2'd2, 16'h8000, 1'b0, "R8 block in level 2 region");

        // R9 chip erase with level 0, R11 and R6 while busy
        send_cmd(8'h06);
        send_wrsr(8'h00);
        wait_done();
        send_cmd(8'h06);
        request(2'd3, 16'h0000, 1'b1, "R9 chip erase at level 0");
        request(2'd0, 16'h0000, 1'b0, "R11 request while busy");
        send_wrsr(8'h0C);
        read_status(1, 8'h03, "R11 R6 busy refusals keep latch and level");
        wait_done();
        read_status(1, 8'h00, "R10 latch cleared after chip erase");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule